// File: doc/BRIEF.md
# Packet History Sequencer

This block stands on the ingress path ahead of a group of processing cores that all keep a copy of the same per-flow state. Each arriving packet gets a sequence number in arrival order. One field is taken from its first beat, and the pair is kept as a history entry in a small ring. Every packet leaves with a prefix made of the most recent entries and its own entry, followed by its unchanged bytes. A core that receives only some of the packets can therefore replay the state updates of the packets that went to the other cores, and no core has to synchronise with another.

Both sides are AXI4-Stream with 64-bit beats. The field's byte offset comes from a configuration input. A second configuration input adds a placeholder Ethernet header in front of the prefix, so a network adapter placed after the block can still parse the frame. Output packets go to the cores in turn, and the chosen core is carried on `tdest`. While the prefix is streamed, the block holds back its input. It never drops or reorders a packet.

Top module: `pkt_hist_seq`

## Requirements
- R1: After reset, `m_tvalid` and `s_tready` are low. The first packet gets sequence number 0 and `m_tdest` 0.
- R2: An output packet has this beat order: optional placeholder beats, one mask beat, `DEPTH` history beats, the current-entry beat, then the input beats unchanged. `m_tlast` is high only on the copy of the input's last beat.
- R3: An entry beat is {sequence number in bits 63:32, extracted field in bits 31:0}.
- R4: The field is the 32 bits of the packet's first beat that start at byte `cfg_field_off`. Byte b occupies bits 8b+7:8b. Bytes past the end of the beat read as zero. The offset is sampled when the packet starts.
- R5: Sequence numbers count up by one per packet, with no gaps.
- R6: The history beats hold the entries of the `DEPTH` packets just before this one, oldest first. Older entries are dropped.
- R7: Bit k of the mask beat is 1 when history slot k (k=0 is the oldest) holds an entry. All other mask bits are 0. While the ring is not yet full, the empty slots come first and carry all-zero data.
- R8: With `cfg_dummy_en` high at packet start, two beats come first: 64'h0000FFFFFFFFFFFF and then 64'h0000B58800000000 (broadcast destination, zero source, type 0x88B5).
- R9: `m_tdest` cycles 0,1,…,`NUM_CORES`-1 and wraps, advancing once per packet. It is constant within a packet.
- R10: `s_tready` stays low until the current-entry beat has been accepted. After that, an input beat is taken only in the same cycle it is accepted at the output.
- R11: While `m_tvalid` is high and `m_tready` is low, the output beat, `m_tlast` and `m_tdest` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_field_off | input | 3 | Byte offset of the extracted field |
| cfg_dummy_en | input | 1 | Enables the placeholder header |
| s_tdata | input | 64 | Input beat |
| s_tvalid | input | 1 | Input valid |
| s_tlast | input | 1 | Input last beat |
| s_tready | output | 1 | Input ready |
| m_tdata | output | 64 | Output beat |
| m_tvalid | output | 1 | Output valid |
| m_tlast | output | 1 | Output last beat |
| m_tdest | output | 2 | Target core index |
| m_tready | input | 1 | Output ready |

## Verification
Single-beat and multi-beat packets are sent with each field offset from 0 to 4. These show whether the field comes from the right bytes and whether the body is passed through unchanged. Offsets 5 and 7 show the zero fill past the end of the beat. A run of packets first partly fills the ring and then wraps it, which separates empty-slot padding from real entries and shows that the oldest entry is dropped. The placeholder mode is tried on a packet between two ordinary ones. A stalling output receiver is also used: it separates correct holding of the output and of the input from a block that skips or repeats beats.

// File: rtl/pkt_hist_pkg.sv
// Shared types and constants of the packet history sequencer.
// Assumes 64-bit stream beats; the placeholder beats are defined for that width.
package pkt_hist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PFX  = 2'd1,
        ST_BODY = 2'd2
    } phs_state_e;

    // Placeholder Ethernet header, byte 0 in bits 7:0: broadcast destination,
    // zero source, type 0x88B5 in bytes 12..13, two bytes of padding.
    localparam logic [63:0] PH_BEAT0 = 64'h0000_FFFF_FFFF_FFFF;
    localparam logic [63:0] PH_BEAT1 = 64'h0000_B588_0000_0000;

endpackage

// File: rtl/phs_field_extract.sv
// Takes FLD_W bits from a beat, starting at a byte offset.
// Assumes byte b of the beat sits in bits 8b+7:8b; bytes past the end read as zero.
module phs_field_extract #(
    parameter int DATA_W = 64,
    parameter int FLD_W  = 32,
    parameter int OFF_W  = 3
) (
    input  logic [DATA_W-1:0] beat,
    input  logic [OFF_W-1:0]  byte_off,
    output logic [FLD_W-1:0]  field
);
    localparam int SH_W = OFF_W + 3;

    logic [SH_W-1:0]   shift_bits;
    logic [DATA_W-1:0] shifted;

    // shift the beat right by whole bytes and keep the low field bits
    always_comb begin
        shift_bits = {byte_off, 3'b000};
        shifted    = beat >> shift_bits;
        field      = shifted[FLD_W-1:0];
    end
endmodule

// File: rtl/phs_hist_ring.sv
// Ring of the last DEPTH history entries, with a read port by emission slot.
// Slot 0 is the oldest position of the window. Slots that hold no entry yet
// are reported invalid. Assumes DEPTH >= 2.
module phs_hist_ring #(
    parameter int DEPTH = 4,
    parameter int ENT_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ENT_W-1:0]           wr_data,
    input  logic [$clog2(DEPTH)-1:0]   rd_slot,
    output logic [ENT_W-1:0]           rd_data,
    output logic                       rd_valid,
    output logic [DEPTH-1:0]           valid_mask
);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int FILL_W = SLOT_W + 1;
    localparam logic [FILL_W-1:0] DEPTH_F = FILL_W'(DEPTH);

    logic [ENT_W-1:0]  mem [DEPTH];
    logic [SLOT_W-1:0] wr_ptr;
    logic [FILL_W-1:0] fill;
    logic [FILL_W-1:0] idx_sum;
    logic [SLOT_W-1:0] rd_idx;

    // store the new entry and move the write pointer, counting fill up to DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fill   <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
            wr_ptr      <= (wr_ptr == SLOT_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (fill != DEPTH_F) fill <= fill + 1'b1;
        end
    end

    // map an emission slot to the ring index counted from the oldest position
    always_comb begin
        idx_sum = {1'b0, wr_ptr} + {1'b0, rd_slot};
        rd_idx  = (idx_sum >= DEPTH_F) ? SLOT_W'(idx_sum - DEPTH_F) : SLOT_W'(idx_sum);
    end

    // mark slots that hold an entry: the newest 'fill' slots of the window
    for (genvar k = 0; k < DEPTH; k++) begin : g_mask
        assign valid_mask[k] = (FILL_W'(k) >= (DEPTH_F - fill));
    end

    // read data, forced to zero for empty slots
    always_comb begin
        rd_valid = valid_mask[rd_slot];
        rd_data  = rd_valid ? mem[rd_idx] : '0;
    end

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= DEPTH_F);

    // R7
    mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (valid_mask != '1) |=> $countones(valid_mask) == $countones($past(valid_mask)) + 1);
endmodule

// File: rtl/phs_core_rr.sv
// Round-robin pointer over NUM_CORES targets; moves once per finished packet.
// Assumes advance pulses for one cycle at the end of a packet.
module phs_core_rr #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [CORE_W-1:0] core
);
    // step to the next core and wrap after the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core <= '0;
        end else if (advance) begin
            core <= (core == CORE_W'(NUM_CORES - 1)) ? '0 : core + 1'b1;
        end
    end

    // R9
    core_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core <= CORE_W'(NUM_CORES - 1));

    // R9
    core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(core));
endmodule

// File: rtl/pkt_hist_seq.sv
// Packet history sequencer top. For each packet it peeks the first beat,
// builds the entry {sequence, field}, streams the prefix (placeholder beats,
// mask, history oldest first, own entry) while holding the input, then passes
// the packet body through. Assumes 64-bit beats and DEPTH <= 64.
module pkt_hist_seq
    import pkt_hist_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int SEQ_W     = 32,
    parameter int DEPTH     = 4,
    parameter int NUM_CORES = 4,
    parameter int OFF_W     = 3,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  cfg_field_off,
    input  logic              cfg_dummy_en,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    output logic [CORE_W-1:0] m_tdest,
    input  logic              m_tready
);
    localparam int FLD_W   = DATA_W - SEQ_W;
    localparam int SLOT_W  = $clog2(DEPTH);
    localparam int POS_MAX = DEPTH + 3;
    localparam int POS_W   = $clog2(POS_MAX + 1);
    localparam logic [POS_W-1:0] POS_PH1  = POS_W'(1);
    localparam logic [POS_W-1:0] POS_MASK = POS_W'(2);
    localparam logic [POS_W-1:0] POS_HIST = POS_W'(3);
    localparam logic [POS_W-1:0] POS_CUR  = POS_W'(POS_MAX);

    phs_state_e        st;
    logic [POS_W-1:0]  pos;
    logic [SEQ_W-1:0]  seq_cnt;
    logic [DATA_W-1:0] cur_entry;
    logic [FLD_W-1:0]  field;
    logic              wr_en;
    logic              pkt_end;
    logic [SLOT_W-1:0] rd_slot;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic [DEPTH-1:0]  valid_mask;
    logic [DATA_W-1:0] pfx_beat;

    phs_field_extract #(
        .DATA_W (DATA_W),
        .FLD_W  (FLD_W),
        .OFF_W  (OFF_W)
    ) u_extract (
        .beat     (s_tdata),
        .byte_off (cfg_field_off),
        .field    (field)
    );

    phs_hist_ring #(
        .DEPTH (DEPTH),
        .ENT_W (DATA_W)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (cur_entry),
        .rd_slot    (rd_slot),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .valid_mask (valid_mask)
    );

    phs_core_rr #(
        .NUM_CORES (NUM_CORES),
        .CORE_W    (CORE_W)
    ) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (pkt_end),
        .core    (m_tdest)
    );

    // events: entry committed at the last prefix beat, packet finished at body tlast
    always_comb begin
        wr_en   = (st == ST_PFX) && m_tready && (pos == POS_CUR);
        pkt_end = (st == ST_BODY) && s_tvalid && m_tready && s_tlast;
    end

    // packet sequencing: peek first beat, walk prefix positions, pass body
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            pos       <= '0;
            seq_cnt   <= '0;
            cur_entry <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (s_tvalid) begin
                        st        <= ST_PFX;
                        cur_entry <= {seq_cnt, field};
                        pos       <= cfg_dummy_en ? '0 : POS_MASK;
                    end
                end
                ST_PFX: begin
                    if (m_tready) begin
                        if (pos == POS_CUR) begin
                            st      <= ST_BODY;
                            seq_cnt <= seq_cnt + 1'b1;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end
                end
                ST_BODY: begin
                    if (pkt_end) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // history slot addressed by the current prefix position
    always_comb begin
        rd_slot = SLOT_W'(pos - POS_HIST);
    end

    // prefix beat selected by position
    always_comb begin
        if (pos == '0)             pfx_beat = PH_BEAT0;
        else if (pos == POS_PH1)   pfx_beat = PH_BEAT1;
        else if (pos == POS_MASK)  pfx_beat = DATA_W'(valid_mask);
        else if (pos == POS_CUR)   pfx_beat = cur_entry;
        else                       pfx_beat = rd_valid ? rd_data : '0;
    end

    // output and input handshake per state
    always_comb begin
        m_tdata  = '0;
        m_tvalid = 1'b0;
        m_tlast  = 1'b0;
        s_tready = 1'b0;
        case (st)
            ST_PFX: begin
                m_tdata  = pfx_beat;
                m_tvalid = 1'b1;
            end
            ST_BODY: begin
                m_tdata  = s_tdata;
                m_tvalid = s_tvalid;
                m_tlast  = s_tlast;
                s_tready = m_tready;
            end
            default: ;
        endcase
    end

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready && (st == ST_PFX) |=>
            m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tdest));

    // R10
    in_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_tvalid && s_tready |-> m_tvalid && m_tready && (m_tdata == s_tdata));

    // R5
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> seq_cnt == $past(seq_cnt) + 1'b1);

    // R5
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(seq_cnt));

    // R9
    dest_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) && !pkt_end |=> $stable(m_tdest));
endmodule

// File: tb/pkt_hist_seq_tb_top.sv
// Directed bench for the packet history sequencer.
module pkt_hist_seq_tb_top;
    localparam int N  = 4;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_field_off = '0;
    logic        cfg_dummy_en = 1'b0;
    logic [63:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic [63:0] m_tdata;
    logic        m_tvalid;
    logic        m_tlast;
    logic [1:0]  m_tdest;
    logic        m_tready = 1'b1;

    int total = 0;
    int bad = 0;

    logic [63:0] hist_q[$];
    int          seq_m = 0;
    int          core_m = 0;

    logic [63:0] got [32];
    logic [1:0]  got_dest [32];
    int          got_n;
    int          blk_bad;
    int          hold_bad;

    always #4 clk = ~clk;

    pkt_hist_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_field_off (cfg_field_off),
        .cfg_dummy_en  (cfg_dummy_en),
        .s_tdata       (s_tdata),
        .s_tvalid      (s_tvalid),
        .s_tlast       (s_tlast),
        .s_tready      (s_tready),
        .m_tdata       (m_tdata),
        .m_tvalid      (m_tvalid),
        .m_tlast       (m_tlast),
        .m_tdest       (m_tdest),
        .m_tready      (m_tready)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] body_beat(input logic [63:0] base, input int i);
        return base ^ (64'h0123_4567_89AB_CDEF * (i + 1));
    endfunction

    function automatic logic [31:0] ref_field(input logic [63:0] beat, input int off);
        logic [31:0] f = '0;
        for (int b = 0; b < 4; b++)
            if (off + b < 8) f[8*b +: 8] = beat[8*(off+b) +: 8];
        return f;
    endfunction

    task automatic drive(input int n, input logic [63:0] base);
        bit acc;
        @(posedge clk); #1;
        for (int i = 0; i < n; i++) begin
            s_tvalid = 1'b1;
            s_tdata  = body_beat(base, i);
            s_tlast  = (i == n - 1);
            do begin
                @(negedge clk); acc = s_tready;
                @(posedge clk); #1;
            end while (!acc);
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic collect(input bit stall, input int pfx_len);
        bit done = 0;
        bit hold_pend = 0;
        logic [63:0] held = '0;
        int cyc = 0;
        got_n = 0; blk_bad = 0; hold_bad = 0;
        @(posedge clk); #1;
        while (!done) begin
            m_tready = stall ? (cyc % 3 != 2) : 1'b1;
            cyc++;
            @(negedge clk);
            if (hold_pend && !(m_tvalid && m_tdata == held)) hold_bad++;
            hold_pend = m_tvalid && !m_tready;
            held = m_tdata;
            if (got_n < pfx_len && s_tready) blk_bad++;
            if (m_tvalid && m_tready) begin
                got[got_n] = m_tdata;
                got_dest[got_n] = m_tdest;
                if (m_tlast) done = 1;
                got_n++;
            end
            @(posedge clk); #1;
        end
        m_tready = 1'b1;
    endtask

    // sends one packet and checks every output beat against the bench model
    task automatic run_pkt(input int n, input logic [63:0] base, input int off,
                           input bit dummy, input bit stall);
        int pfx_len = (dummy ? 2 : 0) + N + 2;
        int p = 0;
        int cnt = hist_q.size();
        logic [63:0] mask = '0;
        logic [63:0] cur;
        bit dest_ok = 1;
        cfg_field_off = 3'(off);
        cfg_dummy_en  = dummy;
        cur = {32'(seq_m), ref_field(body_beat(base, 0), off)};
        fork
            drive(n, base);
            collect(stall, pfx_len);
        join
        chk(got_n == pfx_len + n, "R2 length", 64'(got_n), 64'(pfx_len + n));
        if (got_n == pfx_len + n) begin
            if (dummy) begin
                chk(got[0] == 64'h0000_FFFF_FFFF_FFFF, "R8 ph0", got[0], 64'h0000_FFFF_FFFF_FFFF);
                chk(got[1] == 64'h0000_B588_0000_0000, "R8 ph1", got[1], 64'h0000_B588_0000_0000);
                p = 2;
            end
            for (int k = 0; k < N; k++) if (k >= N - cnt) mask[k] = 1'b1;
            chk(got[p] == mask, "R7 mask", got[p], mask);
            for (int k = 0; k < N; k++) begin
                logic [63:0] e = (k >= N - cnt) ? hist_q[k - (N - cnt)] : 64'h0;
                chk(got[p+1+k] == e, "R6 hist slot", got[p+1+k], e);
            end
            chk(got[p+1+N] == cur, "R3 entry", got[p+1+N], cur);
            chk(got[p+1+N][63:32] == 32'(seq_m), "R5 seq", 64'(got[p+1+N][63:32]), 64'(seq_m));
            chk(got[p+1+N][31:0] == cur[31:0], "R4 field", 64'(got[p+1+N][31:0]), 64'(cur[31:0]));
            for (int i = 0; i < n; i++)
                chk(got[pfx_len+i] == body_beat(base, i), "R2 body", got[pfx_len+i], body_beat(base, i));
            for (int i = 0; i < got_n; i++) if (got_dest[i] != 2'(core_m)) dest_ok = 0;
            chk(dest_ok, "R9 tdest", 64'(got_dest[0]), 64'(core_m));
        end
        chk(blk_bad == 0, "R10 input held during prefix", 64'(blk_bad), 64'd0);
        if (stall) chk(hold_bad == 0, "R11 output hold", 64'(hold_bad), 64'd0);
        hist_q.push_back(cur);
        if (hist_q.size() > N) void'(hist_q.pop_front());
        seq_m++;
        core_m = (core_m + 1) % NC;
        repeat (2) @(posedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R1 m_tvalid after reset", 64'(m_tvalid), 64'd0);
        chk(s_tready == 1'b0, "R1 s_tready after reset", 64'(s_tready), 64'd0);
        chk(m_tdest == 2'd0, "R1 tdest after reset", 64'(m_tdest), 64'd0);
    endtask

    task automatic t_first();
        run_pkt(1, 64'h1111_2222_3333_4444, 0, 0, 0);
    endtask

    task automatic t_fill();
        run_pkt(2, 64'hA5A5_0000_FFFF_1234, 1, 0, 0);
        run_pkt(3, 64'h0F0F_1E1E_2D2D_3C3C, 2, 0, 0);
        run_pkt(1, 64'hDEAD_BEEF_CAFE_F00D, 3, 0, 0);
        run_pkt(4, 64'h7654_3210_FEDC_BA98, 4, 0, 0);
    endtask

    task automatic t_wrap();
        run_pkt(2, 64'h1357_9BDF_2468_ACE0, 5, 0, 0);
        run_pkt(1, 64'hFFEE_DDCC_BBAA_9988, 7, 0, 0);
        run_pkt(3, 64'h0000_0001_0000_0002, 0, 0, 0);
    endtask

    task automatic t_dummy();
        run_pkt(2, 64'h5555_AAAA_5555_AAAA, 2, 1, 0);
        run_pkt(1, 64'h3141_5926_5358_9793, 1, 0, 0);
    endtask

    task automatic t_stall();
        run_pkt(3, 64'h2718_2818_2845_9045, 0, 0, 1);
        run_pkt(2, 64'h1618_0339_8874_9894, 3, 1, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog expired");
        total++;
        bad++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_first();
        t_fill();
        t_wrap();
        t_dummy();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule